// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Decay Control

This block drives the four switches of one full bridge that feeds a motor winding. It takes a direction bit, a request to drive the winding, a choice between fast and slow current decay, and a master enable. From these it makes four gate signals: a high-side and a low-side gate for leg A, and the same pair for leg B. Its main job is to keep the two switches of a leg from conducting together, so it puts a programmable dead interval into every change of the switch pattern.

When the drive request is withdrawn, the winding current must keep flowing while it decays. In fast decay the block opens both driving switches. After the dead interval it closes only the low-side switch that sits beside the diode carrying the current, so the current cannot build up in the reverse direction. In slow decay only the driving low-side switch opens. The current then circulates through the two high-side switches, and after the dead interval the other high-side switch closes as a synchronous rectifier.

Each time the wanted pattern changes, the block first keeps only the switches that the old and new patterns have in common. It holds that reduced pattern for `DEAD_CYC` clock cycles and then applies the new pattern. Turning the enable off opens every switch at once.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While reset is held, and until the first dead interval after reset has elapsed, all four gates are off.
- R2: With the drive request high, direction 1 closes the leg A high gate and the leg B low gate, and direction 0 closes the leg B high gate and the leg A low gate. The gate vector {hi_a, lo_a, hi_b, lo_b} is 1001 for direction 1 and 0110 for direction 0.
- R3: In fast decay (decay select 0) with the request low, all gates are off during the dead interval. After it, only the leg A low gate is on for direction 1 (0100), and only the leg B low gate is on for direction 0 (0001).
- R4: In slow decay (decay select 1) with the request low, only the driving low gate opens during the dead interval, and the driving high gate stays on. After the interval both high gates are on (1010).
- R5: When the pattern changes, the gates common to the old and new patterns stay on for exactly DEAD_CYC clock edges after the edge that samples the change. The new pattern appears on the next edge, so every turn-on waits out the dead interval.
- R6: A direction change while driving turns all four gates off for the dead interval, then applies the opposite diagonal.
- R7: Enable low forces all gates off in the same cycle, without waiting for a clock edge. When enable returns, the gates stay off for a full dead interval before the wanted pattern appears.
- R8: The high and low gates of one leg are never on in the same cycle.
- R9: A change of the wanted pattern during a dead interval restarts the interval. The new pattern appears DEAD_CYC+1 edges after the last change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Master enable; low opens all switches |
| drive_req | input | 1 | 1 = drive the winding, 0 = off-time (decay) |
| phase | input | 1 | Current direction through the winding |
| slow_decay | input | 1 | 1 = slow decay, 0 = fast decay |
| gate_hi_a | output | 1 | Leg A high-side gate |
| gate_lo_a | output | 1 | Leg A low-side gate |
| gate_hi_b | output | 1 | Leg B high-side gate |
| gate_lo_b | output | 1 | Leg B low-side gate |

## Verification
Two functions of this block can fall in the same cycle: the dead-interval countdown, and either a fresh pattern change or the removal of the enable. The bench changes direction partway through a running dead interval. It then checks that the all-off pattern still holds one cycle before the restarted deadline and that the new diagonal appears on the deadline itself. It also drops the enable while the gates are driving and checks that the outputs go to zero before the next edge. Finally, it checks that re-enabling costs a full dead interval.

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq #(
  parameter int DEAD_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic drive_req,
  input  logic phase,
  input  logic slow_decay,
  output logic gate_hi_a,
  output logic gate_lo_a,
  output logic gate_hi_b,
  output logic gate_lo_b
);
  localparam int CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEAD_CYC - 1);

  // gate vector order: {hi_a, lo_a, hi_b, lo_b}
  localparam logic [3:0] DRV_P1  = 4'b1001;
  localparam logic [3:0] DRV_P0  = 4'b0110;
  localparam logic [3:0] FAST_P1 = 4'b0100;
  localparam logic [3:0] FAST_P0 = 4'b0001;
  localparam logic [3:0] SLOW    = 4'b1010;

  logic [3:0]    target, applied, goal;
  logic          busy;
  logic [CW-1:0] cnt;

  always_comb begin
    if (drive_req)       target = phase ? DRV_P1 : DRV_P0;
    else if (slow_decay) target = SLOW;
    else                 target = phase ? FAST_P1 : FAST_P0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      applied <= '0;
      goal    <= '0;
      busy    <= 1'b0;
      cnt     <= '0;
    end else if (target != (busy ? goal : applied)) begin
      applied <= applied & target;
      goal    <= target;
      busy    <= 1'b1;
      cnt     <= '0;
    end else if (busy) begin
      if (cnt == CNT_LAST) begin
        applied <= goal;
        busy    <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign gate_hi_a = applied[3] & enable;
  assign gate_lo_a = applied[2] & enable;
  assign gate_hi_b = applied[1] & enable;
  assign gate_lo_b = applied[0] & enable;
endmodule

module hbridge_gate_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic gate_hi_a,
  input logic gate_lo_a,
  input logic gate_hi_b,
  input logic gate_lo_b
);
  // R8
  leg_a_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi_a && gate_lo_a));
  // R8
  leg_b_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi_b && gate_lo_b));
  // R7
  off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !(gate_hi_a || gate_lo_a || gate_hi_b || gate_lo_b));
  // R5
  lo_a_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo_a) |-> $past(!gate_hi_a));
  // R5
  hi_a_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi_a) |-> $past(!gate_lo_a));
  // R5
  lo_b_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo_b) |-> $past(!gate_hi_b));
  // R5
  hi_b_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi_b) |-> $past(!gate_lo_b));
  // R2
  two_on_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b}) <= 2);
endmodule

bind hbridge_gate_seq hbridge_gate_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .gate_hi_a(gate_hi_a), .gate_lo_a(gate_lo_a),
  .gate_hi_b(gate_hi_b), .gate_lo_b(gate_lo_b)
);

// File: tb/hbridge_gate_seq_tb.sv
module hbridge_gate_seq_tb_top;
  localparam int DEAD = 6;

  logic clk = 1'b0;
  logic rst_n, enable, drive_req, phase, slow_decay;
  logic gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b;
  int checks = 0, failures = 0, leg_viol = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hbridge_gate_seq #(.DEAD_CYC(DEAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .drive_req(drive_req),
    .phase(phase), .slow_decay(slow_decay),
    .gate_hi_a(gate_hi_a), .gate_lo_a(gate_lo_a),
    .gate_hi_b(gate_hi_b), .gate_lo_b(gate_lo_b)
  );

  wire [3:0] g = {gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b};

  // {req, phase, slow, mid[3:0], final[3:0], req_tag[3:0]}
  localparam logic [14:0] VEC [13] = '{
    {3'b110, 4'b0000, 4'b1001, 4'd2},  // R2
    {3'b010, 4'b0000, 4'b0100, 4'd3},  // R3
    {3'b110, 4'b0000, 4'b1001, 4'd5},  // R5
    {3'b011, 4'b1000, 4'b1010, 4'd4},  // R4
    {3'b111, 4'b1000, 4'b1001, 4'd5},  // R5
    {3'b101, 4'b0000, 4'b0110, 4'd6},  // R6
    {3'b001, 4'b0010, 4'b1010, 4'd4},  // R4
    {3'b101, 4'b0010, 4'b0110, 4'd5},  // R5
    {3'b000, 4'b0000, 4'b0001, 4'd3},  // R3
    {3'b100, 4'b0000, 4'b0110, 4'd2},  // R2
    {3'b110, 4'b0000, 4'b1001, 4'd6},  // R6
    {3'b011, 4'b1000, 4'b1010, 4'd4},  // R4
    {3'b010, 4'b0000, 4'b0100, 4'd3}   // R3
  };

  always @(negedge clk)
    if (rst_n === 1'b1 && ((gate_hi_a & gate_lo_a) | (gate_hi_b & gate_lo_b)))
      leg_viol++;

  task automatic check(input logic [3:0] got, input logic [3:0] exp, input int tag,
                       input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=%b expected=%b", tag, what, got, exp);
    end
  endtask

  task automatic settle(input logic [3:0] mid, input logic [3:0] fin, input int tag);
    repeat (DEAD) @(negedge clk);
    check(g, mid, tag, "during dead interval");
    @(negedge clk);
    check(g, fin, tag, "after dead interval");
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b1; drive_req = 1'b0; phase = 1'b1; slow_decay = 1'b0;
    repeat (4) @(negedge clk);
    check(g, 4'b0000, 1, "in reset");                  // R1
    rst_n = 1'b1;
    settle(4'b0000, 4'b0100, 1);                       // R1 then fast off pattern

    for (int i = 0; i < 13; i++) begin
      {drive_req, phase, slow_decay} = VEC[i][14:12];
      settle(VEC[i][11:8], VEC[i][7:4], int'(VEC[i][3:0]));
    end

    // R9: restart of dead interval on a change midway
    drive_req = 1'b1; phase = 1'b1;
    repeat (3) @(negedge clk);
    check(g, 4'b0000, 9, "first interval running");
    phase = 1'b0;
    settle(4'b0000, 4'b0110, 9);

    // R7: enable drop acts without a clock edge
    enable = 1'b0;
    #1 check(g, 4'b0000, 7, "immediate disable");
    @(negedge clk);
    check(g, 4'b0000, 7, "held disabled");
    enable = 1'b1;
    settle(4'b0000, 4'b0110, 7);

    checks++;
    if (leg_viol != 0) begin
      failures++;
      $display("FAIL R8 leg overlap: actual=%0d expected=0", leg_viol);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule